// File: doc/BRIEF.md
# Single-Bank DRAM Command Sequencer

This block drives one DRAM bank. A requester hands it one access at a time through a ready/valid handshake: a read or write flag, a row and a column. The block turns each access into the bank's command stream of activate, column read or write, and precharge. It remembers whether a row sits open in the row buffer and which row that is, so that it can serve a row hit with a column command alone.

A mode input chooses the row-buffer policy. With the open policy, the row stays open after the access and is closed only when a different row, a refresh or self-refresh needs the bank. With the closed policy, every column command is followed at once by a precharge. A periodic timer asks for one refresh at a time, each aimed at the next row of a wrapping counter, so that refresh work is spread out and never holds the bank for long. A self-refresh request parks the bank in a low-power state, and leaving that state is followed by a fixed quiet period.

Top module: `bank_cmd_seq`

## Requirements
- R1: After reset the command output is NOP (code 0), the address output is zero, the request input is ready, the low-power flag is low and no row is open.
- R2: Command codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4, REF=5, SRE=6, SRX=7, each shown for one cycle. ACT and REF carry a row and RD/WR a column on the address output, zero-extended; PRE, SRE and SRX carry zero. An RD or WR is issued only while the row of its request is open.
- R3: With the open policy, a request whose row equals the row of the previous column command, with no refresh, self-refresh or policy change between them, is served with no ACT or PRE in between.
- R4: An ACT is issued only while no row is open; a request to another row than the open one is preceded by PRE and then ACT of the new row.
- R5: With the closed policy, a PRE is issued in the cycle that follows every RD or WR.
- R6: Two ACT commands are at least T_RC cycles apart.
- R7: After ACT the next command waits at least T_RCD cycles, after PRE at least T_RP cycles and after REF at least T_RFC cycles.
- R8: REF is issued only while no row is open, and successive REF commands (or the first REF after reset or after leaving self-refresh) are no more than REF_INTERVAL plus a bounded service delay apart.
- R9: The row carried by successive REF commands counts up by one, wrapping from the top row back to row 0.
- R10: Each accepted request is served by exactly one RD or WR of the matching kind, in the order of acceptance.
- R11: SRE is issued only with no row open; from SRE until SRX the command output stays NOP, the low-power flag is high and the request input is not ready.
- R12: SRX is issued once the self-refresh request falls, and no command follows it for T_XS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| close_page | input | 1 | 1 selects the closed row policy, 0 the open policy |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block takes the request at this edge |
| req_write | input | 1 | 1 for write, 0 for read |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| sr_req | input | 1 | Level request for self-refresh |
| sr_active | output | 1 | Bank is in self-refresh |
| cmd_o | output | 3 | Command code |
| addr_o | output | ADDR_W | Row or column for the command |

## Verification
The bench builds the block with a 4-bit row, a 5-bit column, T_RCD=3, T_RP=3, T_RC=8, T_RFC=6, T_XS=10 and REF_INTERVAL=48. The short refresh period brings many refreshes, a full wrap of the refresh row counter and collisions between refresh and open rows into a run of a few thousand cycles, while a narrow row range makes hits, misses and close-page traffic all frequent. The short exit delay lets several self-refresh entries, some with a row open, fit in the same run.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_SRE = 3'd6,
    CMD_SRX = 3'd7
  } bcs_cmd_e;

  // Minimum number of cycles from a command to the next command.
  function automatic int unsigned gap_cycles(bcs_cmd_e c, int unsigned t_rcd,
                                             int unsigned t_rp, int unsigned t_rfc,
                                             int unsigned t_xs);
    int unsigned g;
    case (c)
      CMD_ACT: g = t_rcd;
      CMD_PRE: g = t_rp;
      CMD_REF: g = t_rfc;
      CMD_SRX: g = t_xs;
      default: g = 1;
    endcase
    if (g == 0) g = 1;
    return g;
  endfunction

  function automatic logic is_column(bcs_cmd_e c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction

endpackage

// File: rtl/bcs_refresh_timer.sv
module bcs_refresh_timer #(
  parameter int REF_INTERVAL = 6240,
  parameter int ROW_W        = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             ack,
  output logic             due,
  output logic [ROW_W-1:0] ref_row
);
  localparam int CNT_W = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REF_INTERVAL - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             due_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      due_q <= 1'b0;
      row_q <= '0;
    end else begin
      if (ack) row_q <= row_q + 1'b1;
      if (hold) begin
        cnt_q <= '0;
        due_q <= 1'b0;
      end else if (cnt_q == CNT_LAST) begin
        cnt_q <= '0;
        due_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (ack) due_q <= 1'b0;
      end
    end
  end

  assign due     = due_q;
  assign ref_row = row_q;

  AST_REF_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (ref_row == $past(ref_row) + 1'b1)); // R9
  AST_REF_ONLY_WHEN_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> due); // R8
endmodule

// File: rtl/bcs_act_spacer.sv
module bcs_act_spacer #(
  parameter int T_RC = 39
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_fire,
  output logic act_ok
);
  localparam int SP_W = $clog2(T_RC + 1);
  localparam logic [SP_W-1:0] SP_LOAD = SP_W'((T_RC > 0) ? T_RC - 1 : 0);

  logic [SP_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                left_q <= '0;
    else if (act_fire)         left_q <= SP_LOAD;
    else if (left_q != '0)     left_q <= left_q - 1'b1;
  end

  assign act_ok = (left_q == '0);

  AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |-> act_ok); // R6
endmodule

// File: rtl/bcs_sequencer.sv
module bcs_sequencer
  import bcs_pkg::*;
#(
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 14,
  parameter int T_RCD  = 11,
  parameter int T_RP   = 11,
  parameter int T_RFC  = 208,
  parameter int T_XS   = 216
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              close_page,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              sr_req,
  input  logic              ref_due,
  input  logic [ROW_W-1:0]  ref_row,
  input  logic              act_ok,
  output logic              req_ready,
  output logic              act_fire,
  output logic              ref_fire,
  output logic              sr_active,
  output logic [2:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int WAIT_W = $clog2(T_RCD + T_RP + T_RFC + T_XS + 2);

  typedef enum logic {ST_RUN, ST_SR} seq_st_e;

  seq_st_e          st_q;
  logic [WAIT_W-1:0] wait_q;
  logic             open_q;
  logic [ROW_W-1:0] open_row_q;
  logic             have_q;
  logic             rq_wr_q;
  logic [ROW_W-1:0] rq_row_q;
  logic [COL_W-1:0] rq_col_q;
  bcs_cmd_e         cmd_q;
  logic [ADDR_W-1:0] addr_q;

  bcs_cmd_e          dec;
  logic [ADDR_W-1:0] dec_addr;
  logic              take_req;
  logic              enter_sr;
  logic              leave_sr;
  logic              accept;
  logic              row_hit;

  assign row_hit   = open_q && (open_row_q == rq_row_q);
  assign req_ready = (st_q == ST_RUN) && !have_q && !ref_due && !sr_req;
  assign accept    = req_ready && req_valid;

  always_comb begin
    dec      = CMD_NOP;
    dec_addr = '0;
    take_req = 1'b0;
    enter_sr = 1'b0;
    leave_sr = 1'b0;
    if (wait_q == '0) begin
      if (st_q == ST_SR) begin
        if (!sr_req) begin
          dec      = CMD_SRX;
          leave_sr = 1'b1;
        end
      end else if (close_page && open_q && !have_q) begin
        dec = CMD_PRE;
      end else if (ref_due) begin
        if (open_q) dec = CMD_PRE;
        else begin
          dec      = CMD_REF;
          dec_addr = ADDR_W'(ref_row);
        end
      end else if (sr_req) begin
        if (open_q) dec = CMD_PRE;
        else begin
          dec      = CMD_SRE;
          enter_sr = 1'b1;
        end
      end else if (have_q) begin
        if (row_hit) begin
          dec      = rq_wr_q ? CMD_WR : CMD_RD;
          dec_addr = ADDR_W'(rq_col_q);
          take_req = 1'b1;
        end else if (open_q) begin
          dec = CMD_PRE;
        end else if (act_ok) begin
          dec      = CMD_ACT;
          dec_addr = ADDR_W'(rq_row_q);
        end
      end
    end
  end

  assign act_fire = (dec == CMD_ACT);
  assign ref_fire = (dec == CMD_REF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_RUN;
      wait_q     <= '0;
      open_q     <= 1'b0;
      open_row_q <= '0;
      have_q     <= 1'b0;
      rq_wr_q    <= 1'b0;
      rq_row_q   <= '0;
      rq_col_q   <= '0;
      cmd_q      <= CMD_NOP;
      addr_q     <= '0;
    end else begin
      cmd_q  <= dec;
      addr_q <= dec_addr;
      if (dec != CMD_NOP)
        wait_q <= WAIT_W'(gap_cycles(dec, T_RCD, T_RP, T_RFC, T_XS) - 1);
      else if (wait_q != '0)
        wait_q <= wait_q - 1'b1;
      if (enter_sr) st_q <= ST_SR;
      else if (leave_sr) st_q <= ST_RUN;
      if (dec == CMD_ACT) begin
        open_q     <= 1'b1;
        open_row_q <= rq_row_q;
      end else if (dec == CMD_PRE) begin
        open_q <= 1'b0;
      end
      if (accept) begin
        have_q   <= 1'b1;
        rq_wr_q  <= req_write;
        rq_row_q <= req_row;
        rq_col_q <= req_col;
      end else if (take_req) begin
        have_q <= 1'b0;
      end
    end
  end

  assign sr_active = (st_q == ST_SR);
  assign cmd_o     = cmd_q;
  assign addr_o    = addr_q;

  AST_COL_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    is_column(cmd_q) |-> open_q); // R2
  AST_ACT_ON_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_ACT) |-> $past(!open_q)); // R4
endmodule

// File: rtl/bank_cmd_seq.sv
module bank_cmd_seq
  import bcs_pkg::*;
#(
  parameter int ROW_W        = 14,
  parameter int COL_W        = 10,
  parameter int T_RC         = 39,
  parameter int T_RCD        = 11,
  parameter int T_RP         = 11,
  parameter int T_RFC        = 208,
  parameter int T_XS         = 216,
  parameter int REF_INTERVAL = 6240,
  parameter int ADDR_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              close_page,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              sr_req,
  output logic              sr_active,
  output logic [2:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic             ref_due;
  logic [ROW_W-1:0] ref_row;
  logic             act_ok;
  logic             act_fire;
  logic             ref_fire;

  bcs_refresh_timer #(.REF_INTERVAL(REF_INTERVAL), .ROW_W(ROW_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .hold(sr_active), .ack(ref_fire),
    .due(ref_due), .ref_row(ref_row)
  );

  bcs_act_spacer #(.T_RC(T_RC)) u_spacer (
    .clk(clk), .rst_n(rst_n), .act_fire(act_fire), .act_ok(act_ok)
  );

  bcs_sequencer #(
    .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .T_XS(T_XS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .close_page(close_page),
    .req_valid(req_valid), .req_write(req_write), .req_row(req_row), .req_col(req_col),
    .sr_req(sr_req), .ref_due(ref_due), .ref_row(ref_row), .act_ok(act_ok),
    .req_ready(req_ready), .act_fire(act_fire), .ref_fire(ref_fire),
    .sr_active(sr_active), .cmd_o(cmd_o), .addr_o(addr_o)
  );

  AST_CLOSE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (((cmd_o == CMD_RD) || (cmd_o == CMD_WR)) && close_page) |=> (cmd_o == CMD_PRE)); // R5
  AST_SR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sr_active |-> ((cmd_o == CMD_NOP) || (cmd_o == CMD_SRE))); // R11
  AST_XS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_SRX) |=> (cmd_o == CMD_NOP)); // R12
endmodule

// File: tb/tb_bank_cmd_seq.sv
`timescale 1ns/1ps
module tb_bank_cmd_seq;
  localparam int ROW_W = 4;
  localparam int COL_W = 5;
  localparam int ADDR_W = 5;
  localparam int T_RC = 8;
  localparam int T_RCD = 3;
  localparam int T_RP = 3;
  localparam int T_RFC = 6;
  localparam int T_XS = 10;
  localparam int REF_INT = 48;
  localparam int SLACK = 2 * (T_RCD + T_RP + T_RFC) + T_XS;
  localparam int WD_CYCLES = 150000;

  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_REF = 3'd5, C_SRE = 3'd6, C_SRX = 3'd7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic close_page = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic sr_req = 1'b0;
  logic req_ready, sr_active;
  logic [2:0] cmd_o;
  logic [ADDR_W-1:0] addr_o;

  always #10 clk = ~clk;

  bank_cmd_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .T_RC(T_RC), .T_RCD(T_RCD), .T_RP(T_RP),
    .T_RFC(T_RFC), .T_XS(T_XS), .REF_INTERVAL(REF_INT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .close_page(close_page), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_row(req_row), .req_col(req_col),
    .sr_req(sr_req), .sr_active(sr_active), .cmd_o(cmd_o), .addr_o(addr_o)
  );

  int checks = 0;
  int fails = 0;
  logic done = 1'b0;

  task automatic check(logic ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int spacing_after(logic [2:0] c);
    if (c == C_ACT) return T_RCD;
    if (c == C_PRE) return T_RP;
    if (c == C_REF) return T_RFC;
    if (c == C_SRX) return T_XS;
    return 1;
  endfunction

  // expected request queue
  logic q_wr [0:1023];
  logic [ROW_W-1:0] q_row [0:1023];
  logic [COL_W-1:0] q_col [0:1023];
  int q_head = 0;
  int q_tail = 0;

  // monitor state
  logic mon_on = 1'b0;
  int cyc = 0;
  logic bank_open = 1'b0;
  logic [ROW_W-1:0] bank_row = '0;
  logic in_sr = 1'b0;
  logic [2:0] prev_cmd = C_NOP;
  int prev_cyc = -100;
  int last_act = -100;
  int ref_base = 0;
  logic [ROW_W-1:0] exp_ref_row = '0;
  int refs_seen = 0;
  logic want_pre = 1'b0;
  logic chain_ok = 1'b0;
  logic [ROW_W-1:0] chain_row = '0;
  int acts_since = 0;
  int pres_since = 0;
  int hits_checked = 0;

  always @(negedge clk) begin
    if (mon_on && !done) begin
      cyc++;
      if (want_pre) begin
        check(cmd_o == C_PRE, "R5 pre after column (close policy)", cmd_o, C_PRE);
        want_pre = 1'b0;
      end
      if (in_sr && cmd_o != C_SRX) begin
        check(cmd_o == C_NOP && sr_active && !req_ready, "R11 quiet in self-refresh",
              {cmd_o, sr_active, req_ready}, {C_NOP, 2'b10});
      end
      if (!in_sr && (cyc - ref_base) > REF_INT + SLACK) begin
        check(1'b0, "R8 refresh overdue", cyc - ref_base, REF_INT + SLACK);
        ref_base = cyc;
      end
      if (cmd_o != C_NOP) begin
        check(cyc - prev_cyc >= spacing_after(prev_cmd), "R7/R12 command spacing",
              cyc - prev_cyc, spacing_after(prev_cmd));
        case (cmd_o)
          C_ACT: begin
            check(!bank_open, "R4 act only on closed bank", bank_open, 0);
            check(cyc - last_act >= T_RC, "R6 act to act", cyc - last_act, T_RC);
            last_act = cyc;
            bank_open = 1'b1;
            bank_row = addr_o[ROW_W-1:0];
            acts_since++;
          end
          C_PRE: begin
            check(addr_o == '0, "R2 pre address", addr_o, 0);
            bank_open = 1'b0;
            pres_since++;
          end
          C_RD, C_WR: begin
            if (q_head == q_tail) begin
              check(1'b0, "R10 column without request", q_tail, q_head);
            end else begin
              check(bank_open && bank_row == q_row[q_head], "R2 column on open row",
                    bank_row, q_row[q_head]);
              check(addr_o == ADDR_W'(q_col[q_head]), "R2 column address",
                    addr_o, q_col[q_head]);
              check((cmd_o == C_WR) == q_wr[q_head], "R10 access kind", cmd_o,
                    q_wr[q_head] ? C_WR : C_RD);
              if (!close_page && chain_ok && chain_row == q_row[q_head]) begin
                check(acts_since == 0 && pres_since == 0, "R3 open-row hit",
                      acts_since + pres_since, 0);
                hits_checked++;
              end
              chain_ok = !close_page;
              chain_row = q_row[q_head];
              acts_since = 0;
              pres_since = 0;
              q_head++;
            end
            if (close_page) want_pre = 1'b1;
          end
          C_REF: begin
            check(!bank_open, "R8 refresh on closed bank", bank_open, 0);
            check(addr_o == ADDR_W'(exp_ref_row), "R9 refresh row", addr_o, exp_ref_row);
            check(cyc - ref_base <= REF_INT + SLACK, "R8 refresh spacing",
                  cyc - ref_base, REF_INT + SLACK);
            exp_ref_row = exp_ref_row + 1'b1;
            refs_seen++;
            ref_base = cyc;
            chain_ok = 1'b0;
          end
          C_SRE: begin
            check(!bank_open && sr_active, "R11 enter self-refresh",
                  {bank_open, sr_active}, 1);
            in_sr = 1'b1;
            chain_ok = 1'b0;
          end
          C_SRX: begin
            check(in_sr && !sr_req, "R12 exit on request drop", {in_sr, sr_req}, 2);
            in_sr = 1'b0;
            ref_base = cyc;
          end
          default: ;
        endcase
        prev_cmd = cmd_o;
        prev_cyc = cyc;
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    check(1'b0, "watchdog", WD_CYCLES, 0);
    finish_run();
  end

  task automatic send(logic wr, logic [ROW_W-1:0] row, logic [COL_W-1:0] col);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_row = row;
    req_col = col;
    while (!req_ready) @(negedge clk);
    q_wr[q_tail] = wr;
    q_row[q_tail] = row;
    q_col[q_tail] = col;
    q_tail++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (q_head != q_tail) @(negedge clk);
    repeat (T_RP + 4) @(negedge clk);
  endtask

  task automatic set_policy(logic cp);
    drain();
    @(negedge clk);
    close_page = cp;
    chain_ok = 1'b0;
  endtask

  task automatic self_refresh(int hold_cycles);
    @(negedge clk);
    sr_req = 1'b1;
    repeat (hold_cycles) @(negedge clk);
    sr_req = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cmd_o == C_NOP, "R1 reset command", cmd_o, C_NOP);
    check(addr_o == '0, "R1 reset address", addr_o, 0);
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    check(sr_active == 1'b0, "R1 low-power flag", sr_active, 0);
    mon_on = 1'b1;

    // directed: open policy hit then miss
    send(1'b0, 4'd5, 5'd3);
    send(1'b1, 4'd5, 5'd7);
    send(1'b0, 4'd9, 5'd1);
    send(1'b0, 4'd9, 5'd30);
    drain();
    // self-refresh while a row is open
    self_refresh(25);
    repeat (T_XS + 4) @(negedge clk);
    send(1'b1, 4'd2, 5'd31);

    // close policy directed and random
    set_policy(1'b1);
    send(1'b0, 4'd2, 5'd4);
    send(1'b0, 4'd2, 5'd5);
    for (int i = 0; i < 120; i++) begin
      repeat ($urandom % 4) @(negedge clk);
      send(1'($urandom % 2), ROW_W'($urandom % 16), COL_W'($urandom));
    end

    // open policy random with narrow rows for many hits
    set_policy(1'b0);
    for (int i = 0; i < 200; i++) begin
      repeat ($urandom % 3) @(negedge clk);
      send(1'($urandom % 2), ROW_W'($urandom % 3), COL_W'($urandom));
      if (i % 40 == 39) self_refresh(20 + int'($urandom % 20));
    end

    // mixed policy with self-refresh
    set_policy(1'b1);
    for (int i = 0; i < 80; i++) begin
      repeat ($urandom % 5) @(negedge clk);
      send(1'($urandom % 2), ROW_W'($urandom % 4), COL_W'($urandom));
      if (i % 30 == 29) self_refresh(30);
    end
    drain();
    repeat (3 * REF_INT) @(negedge clk);

    check(q_head == q_tail, "R10 all requests served", q_head, q_tail);
    check(refs_seen > (1 << ROW_W), "R9 refresh row wrapped", refs_seen, (1 << ROW_W) + 1);
    check(hits_checked > 0, "R3 hits exercised", hits_checked, 1);
    finish_run();
  end
endmodule